// File: doc/BRIEF.md
# Asynchronous Peripheral Strobe Sequencer

This block moves one 32-bit word per request between an on-chip requester and an external asynchronous device such as an FPGA or an SRAM-like part. It builds every edge of the external handshake from programmable cycle counts: an address setup interval, an address-latch pulse and an address hold interval, then, per data beat, a lead interval from chip select to the strobe, the strobe itself, and a tail interval before chip select drops. Each strobe ends on an internal pulse counter, on an external acknowledge input, or, when the acknowledge is made mandatory, only on that input, with a watchdog that gives up on a silent device.

Two address styles are selectable per request. With the dedicated style the full address sits on separate address pins for the whole transfer and one latch pulse frames it, while the shared bus carries only data. With the shared style the address travels on the shared bus as beats ahead of the data: two address and two data beats on a 16-bit bus, four of each on an 8-bit bus, always most significant part first. Each byte lane driven on the shared bus carries a parity bit of selectable sense, and lane parity is checked on every read beat.

Top module: `xbus_seq`

## Requirements
- R1: After reset, and whenever idle, `cs`, `ale`, `we`, `oe`, `ad_oe`, `busy` and `done` are 0, and `ad_out`, `par_out`, `ext_addr` are all zero.
- R2: Each address beat takes `cfg_asetup`+1 cycles with `ale` low, then `cfg_alewid`+1 cycles with `ale` high, then `cfg_ahold`+1 cycles with `ale` low; `cs` stays low during address beats.
- R3: With `cfg_shared`=0 there is exactly one address beat, `ad_oe` stays low during it, and `ext_addr` equals the request address from the cycle after acceptance through the `done` cycle; with `cfg_shared`=1, `ext_addr` stays zero.
- R4: With `cfg_shared`=1 the shared bus carries address beats then data beats: 2+2 when `cfg_narrow`=0 (16-bit bus) and 4+4 when `cfg_narrow`=1 (8-bit bus, upper byte of `ad_out` zero); `ad_oe` is high on address beats and on write data beats, low on read data beats.
- R5: Beats carry the most significant part first: on a 16-bit bus bits 31:16 then 15:0; on an 8-bit bus bits 31:24, 23:16, 15:8, 7:0. Read beats are assembled in the same order into `rdata`.
- R6: A write data beat holds `cs` high with `we` low for `cfg_we_lead`+1 cycles, raises `we` for the strobe, then keeps `cs` high with `we` low for `cfg_we_tail`+1 cycles.
- R7: A read data beat holds `cs` high with `oe` low for `cfg_oe_lead`+1 cycles, raises `oe` for the strobe, then keeps `cs` high for one cycle; `ad_in` is sampled in the last strobe cycle and `rdata` holds the word after `done`.
- R8: With the direction's external-only bit (`cfg_wr_ext` for writes, `cfg_rd_ext` for reads) at 0, the strobe lasts the pulse count +1 cycles (`cfg_we_wid`/`cfg_oe_wid`), or ends earlier in the first cycle `ack` is high.
- R9: With the external-only bit at 1, the strobe lasts until the cycle `ack` is high, however the pulse count is set.
- R10: With the external-only bit at 1 and no `ack` for `WDOG_CYC` strobe cycles, the strobe drops, remaining beats are abandoned, and the `done` cycle follows at once with `tmo_err` high.
- R11: `par_out[i]` is the parity of `ad_out` byte lane i (bits 8i+7:8i) while `ad_oe` is high: even sense (`cfg_odd`=0) makes the lane plus its bit hold an even count of ones, odd sense an odd count; `par_out` is 0 while `ad_oe` is low.
- R12: `par_err` is high in the `done` cycle of a read when any sampled beat failed its lane check with the same sense; lane 1 is checked only on a 16-bit bus.
- R13: `done` is a one-cycle pulse after the last phase, `busy` is high from the cycle after acceptance through the `done` cycle, and `req_valid` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Word address |
| req_wdata | input | 32 | Write word |
| cfg_shared | input | 1 | 1 = address on shared bus as beats |
| cfg_narrow | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| cfg_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_rd_ext | input | 1 | Reads end only on acknowledge |
| cfg_wr_ext | input | 1 | Writes end only on acknowledge |
| cfg_asetup | input | TIM_W | Address setup count |
| cfg_alewid | input | TIM_W | Latch pulse count |
| cfg_ahold | input | TIM_W | Address hold count |
| cfg_we_lead | input | TIM_W | Chip select to write strobe count |
| cfg_we_wid | input | TIM_W | Write strobe count |
| cfg_we_tail | input | TIM_W | Write strobe end to chip select end count |
| cfg_oe_lead | input | TIM_W | Chip select to read strobe count |
| cfg_oe_wid | input | TIM_W | Read strobe count |
| ext_addr | output | 32 | Dedicated address pins |
| ad_out | output | 16 | Shared bus drive value |
| ad_oe | output | 1 | Shared bus drive enable |
| ad_in | input | 16 | Shared bus sampled value |
| par_out | output | 2 | Lane parity driven |
| par_in | input | 2 | Lane parity received |
| cs | output | 1 | Chip select, active high |
| ale | output | 1 | Address latch enable |
| we | output | 1 | Write strobe, active high |
| oe | output | 1 | Read strobe, active high |
| ack | input | 1 | Transfer acknowledge from device |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read word |
| par_err | output | 1 | Read parity error, with done |
| tmo_err | output | 1 | Acknowledge timeout, with done |

## Verification
A phase counter or beat index that drifts shows at the pins within one cycle as a latch pulse, lead or strobe of the wrong length, or a beat carrying the wrong slice of the word, so the bench compares every output pin against a per-cycle expected waveform built from the request and timing counts. A stale termination choice shows in the strobe cycle where the acknowledge arrives or the pulse count runs out. A wrong assembly order or lane-check mask only shows at the `done` cycle, in `rdata` or `par_err`, so those are compared there and after.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int WORD_W = 32;
    localparam int BUS_W  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASET,
        ST_ALE,
        ST_AHOLD,
        ST_DLEAD,
        ST_DSTRB,
        ST_DTAIL,
        ST_FIN
    } xb_state_e;

    typedef struct packed {
        logic              write;
        logic              shared;
        logic              narrow;
        logic              odd;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } xb_req_t;

    // parity bit of one byte lane with selectable sense
    function automatic logic xb_parity(input logic [7:0] b, input logic odd);
        return (^b) ^ odd;
    endfunction

    // slice of a word carried by beat idx, most significant part first
    function automatic logic [BUS_W-1:0] beat_sel(input logic [WORD_W-1:0] w,
                                                  input logic [1:0] idx,
                                                  input logic narrow);
        logic [WORD_W-1:0] sh;
        if (narrow) begin
            sh = w >> (8 * (3 - int'(idx)));
            return {8'h00, sh[7:0]};
        end
        sh = w >> (16 * (1 - int'(idx[0])));
        return sh[BUS_W-1:0];
    endfunction

endpackage

// File: rtl/xbus_cycle_cnt.sv
module xbus_cycle_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (cnt != '1)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/xbus_lane_par.sv
module xbus_lane_par
    import xbus_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [8*LANES-1:0] data,
    input  logic               odd,
    output logic [LANES-1:0]   par
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par[g] = xb_parity(data[8*g +: 8], odd);
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int TIM_W    = 4,
    parameter int WDOG_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              cfg_shared,
    input  logic              cfg_narrow,
    input  logic              cfg_odd,
    input  logic              cfg_rd_ext,
    input  logic              cfg_wr_ext,
    input  logic [TIM_W-1:0]  cfg_asetup,
    input  logic [TIM_W-1:0]  cfg_alewid,
    input  logic [TIM_W-1:0]  cfg_ahold,
    input  logic [TIM_W-1:0]  cfg_we_lead,
    input  logic [TIM_W-1:0]  cfg_we_wid,
    input  logic [TIM_W-1:0]  cfg_we_tail,
    input  logic [TIM_W-1:0]  cfg_oe_lead,
    input  logic [TIM_W-1:0]  cfg_oe_wid,
    output logic [WORD_W-1:0] ext_addr,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ad_oe,
    input  logic [BUS_W-1:0]  ad_in,
    output logic [1:0]        par_out,
    input  logic [1:0]        par_in,
    output logic              cs,
    output logic              ale,
    output logic              we,
    output logic              oe,
    input  logic              ack,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic              par_err,
    output logic              tmo_err
);
    localparam int LANES = BUS_W / 8;
    localparam int WD_W  = $clog2(WDOG_CYC) + 1;
    localparam int CNT_W = (WD_W > TIM_W + 1) ? WD_W : TIM_W + 1;

    xb_state_e         st, st_nxt;
    xb_req_t           rq;
    logic [1:0]        abeat, dbeat;
    logic              perr_q, tmo_q;
    logic [WORD_W-1:0] rdata_q;
    logic [CNT_W-1:0]  cnt;

    logic [1:0]        beat_last, abeat_last;
    logic [TIM_W-1:0]  t_lead, t_pulse;
    logic              use_ext, strobe_end, wd_hit, tail_done;
    logic              in_addr, in_data, lane_err;
    logic [LANES-1:0]  pgen, pchk;

    // phase interval counter, restarted on every phase change
    xbus_cycle_cnt #(.W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (st_nxt != st),
        .cnt (cnt)
    );

    assign beat_last  = rq.narrow ? 2'd3 : 2'd1;
    assign abeat_last = rq.shared ? beat_last : 2'd0;
    assign t_lead     = rq.write ? cfg_we_lead : cfg_oe_lead;
    assign t_pulse    = rq.write ? cfg_we_wid  : cfg_oe_wid;
    assign use_ext    = rq.write ? cfg_wr_ext  : cfg_rd_ext;
    assign strobe_end = ack || (!use_ext && cnt == CNT_W'(t_pulse));
    assign wd_hit     = use_ext && !ack && cnt == CNT_W'(WDOG_CYC - 1);
    assign tail_done  = rq.write ? (cnt == CNT_W'(cfg_we_tail)) : 1'b1;

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (req_valid) st_nxt = ST_ASET;
            ST_ASET:  if (cnt == CNT_W'(cfg_asetup)) st_nxt = ST_ALE;
            ST_ALE:   if (cnt == CNT_W'(cfg_alewid)) st_nxt = ST_AHOLD;
            ST_AHOLD: if (cnt == CNT_W'(cfg_ahold))
                          st_nxt = (abeat == abeat_last) ? ST_DLEAD : ST_ASET;
            ST_DLEAD: if (cnt == CNT_W'(t_lead)) st_nxt = ST_DSTRB;
            ST_DSTRB: if (strobe_end) st_nxt = ST_DTAIL;
                      else if (wd_hit) st_nxt = ST_FIN;
            ST_DTAIL: if (tail_done)
                          st_nxt = (dbeat == beat_last) ? ST_FIN : ST_DLEAD;
            ST_FIN:   st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    // read beat lane check
    xbus_lane_par #(.LANES(LANES)) u_pchk (.data(ad_in), .odd(rq.odd), .par(pchk));

    always_comb begin
        lane_err = 1'b0;
        for (int i = 0; i < LANES; i++)
            if (i == 0 || !rq.narrow)
                lane_err = lane_err | (pchk[i] ^ par_in[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            rq      <= '0;
            abeat   <= '0;
            dbeat   <= '0;
            perr_q  <= 1'b0;
            tmo_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            st <= st_nxt;
            if (st == ST_IDLE && req_valid) begin
                rq      <= '{write: req_write, shared: cfg_shared, narrow: cfg_narrow,
                             odd: cfg_odd, addr: req_addr, wdata: req_wdata};
                abeat   <= '0;
                dbeat   <= '0;
                perr_q  <= 1'b0;
                tmo_q   <= 1'b0;
                rdata_q <= '0;
            end
            if (st == ST_AHOLD && st_nxt != ST_AHOLD)
                abeat <= abeat + 1'b1;
            if (st == ST_DTAIL && st_nxt != ST_DTAIL)
                dbeat <= dbeat + 1'b1;
            if (st == ST_DSTRB && strobe_end && !rq.write) begin
                rdata_q <= rq.narrow ? {rdata_q[WORD_W-9:0], ad_in[7:0]}
                                     : {rdata_q[WORD_W-BUS_W-1:0], ad_in};
                perr_q  <= perr_q | lane_err;
            end
            if (st == ST_DSTRB && wd_hit)
                tmo_q <= 1'b1;
        end
    end

    assign in_addr  = (st == ST_ASET) || (st == ST_ALE) || (st == ST_AHOLD);
    assign in_data  = (st == ST_DLEAD) || (st == ST_DSTRB) || (st == ST_DTAIL);
    assign busy     = (st != ST_IDLE);
    assign done     = (st == ST_FIN);
    assign par_err  = done && perr_q;
    assign tmo_err  = done && tmo_q;
    assign rdata    = rdata_q;
    assign cs       = in_data;
    assign ale      = (st == ST_ALE);
    assign we       = (st == ST_DSTRB) && rq.write;
    assign oe       = (st == ST_DSTRB) && !rq.write;
    assign ad_oe    = (in_addr && rq.shared) || (in_data && rq.write);
    assign ext_addr = (busy && !rq.shared) ? rq.addr : '0;
    assign ad_out   = ad_oe ? beat_sel(in_addr ? rq.addr : rq.wdata,
                                       in_addr ? abeat : dbeat, rq.narrow) : '0;

    xbus_lane_par #(.LANES(LANES)) u_pgen (.data(ad_out), .odd(rq.odd), .par(pgen));
    assign par_out = ad_oe ? pgen : '0;

    // ---------------- assertions ----------------
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!cs && !ale && !ad_oe && !we && !oe));

    p_ale_no_cs_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |-> $past(!cs) && !cs);

    p_we_after_cs_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(we) |-> $past(cs));

    p_oe_after_cs_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> $past(cs));

    p_ack_ends_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DSTRB && ack) |=> (st == ST_DTAIL));

    p_ext_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DSTRB && use_ext && !ack && cnt != CNT_W'(WDOG_CYC - 1))
        |=> (st == ST_DSTRB));

    p_tmo_from_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_err) |-> $past(st == ST_DSTRB));

    p_perr_with_done_r12: assert property (@(posedge clk) disable iff (rst)
        par_err |-> done && !rq.write);

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);

endmodule

// File: tb/sim_xbus_seq.sv
`timescale 1ns/1ps
module sim_xbus_seq;
    localparam int TIM_W = 4;
    localparam int WDOG  = 64;

    typedef struct packed {
        logic        cs, ale, we, oe, adoe;
        logic [15:0] ad;
        logic [1:0]  par;
        logic [31:0] ea;
        logic        busy, done, perr, tmo;
    } exp_t;

    logic clk = 0, rst = 1;
    always #2 clk = ~clk;

    logic req_valid = 0, req_write = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic cfg_shared = 0, cfg_narrow = 0, cfg_odd = 0, cfg_rd_ext = 0, cfg_wr_ext = 0;
    logic [TIM_W-1:0] cfg_asetup = 0, cfg_alewid = 0, cfg_ahold = 0;
    logic [TIM_W-1:0] cfg_we_lead = 0, cfg_we_wid = 0, cfg_we_tail = 0;
    logic [TIM_W-1:0] cfg_oe_lead = 0, cfg_oe_wid = 0;
    logic [31:0] ext_addr, rdata;
    logic [15:0] ad_out, ad_in = 0;
    logic [1:0]  par_out, par_in = 0;
    logic ad_oe, cs, ale, we, oe, ack = 0, busy, done, par_err, tmo_err;

    xbus_seq #(.TIM_W(TIM_W), .WDOG_CYC(WDOG)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_shared(cfg_shared),
        .cfg_narrow(cfg_narrow), .cfg_odd(cfg_odd), .cfg_rd_ext(cfg_rd_ext),
        .cfg_wr_ext(cfg_wr_ext), .cfg_asetup(cfg_asetup), .cfg_alewid(cfg_alewid),
        .cfg_ahold(cfg_ahold), .cfg_we_lead(cfg_we_lead), .cfg_we_wid(cfg_we_wid),
        .cfg_we_tail(cfg_we_tail), .cfg_oe_lead(cfg_oe_lead), .cfg_oe_wid(cfg_oe_wid),
        .ext_addr(ext_addr), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .par_out(par_out), .par_in(par_in), .cs(cs), .ale(ale), .we(we), .oe(oe),
        .ack(ack), .busy(busy), .done(done), .rdata(rdata), .par_err(par_err),
        .tmo_err(tmo_err));

    int   n_cmp = 0, n_bad = 0;
    exp_t q[$];

    // device responder state
    logic [31:0] rd_word = 0;
    int   ack_at = 0, bad_beat = 99, ridx = 0, sn = 0;
    logic [1:0] bad_mask = 0;
    logic prev_strobe = 0;

    function automatic logic lpar(input logic [7:0] b, input logic odd);
        int ones = $countones(b);
        return odd ? logic'((ones % 2) == 0) : logic'((ones % 2) == 1);
    endfunction

    function automatic logic [1:0] bpar(input logic [15:0] v);
        return {lpar(v[15:8], cfg_odd), lpar(v[7:0], cfg_odd)};
    endfunction

    function automatic logic [15:0] beat(input logic [31:0] w, input int i);
        int nb = cfg_narrow ? 4 : 2;
        if (i < 0 || i >= nb) return 16'h0;
        if (cfg_narrow) return 16'((w >> (24 - 8 * i)) & 32'hFF);
        return 16'((w >> (16 - 16 * i)) & 32'hFFFF);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t act=%h exp=%h", tag, $time, act, exp);
        end
    endtask

    task automatic push(input int n, input exp_t v);
        repeat (n) q.push_back(v);
    endtask

    // expected per-cycle waveform from the requirements
    task automatic plan(input bit wr, input logic [31:0] a, input logic [31:0] w,
                        output bit tmo);
        int nb = cfg_narrow ? 4 : 2;
        int na = cfg_shared ? nb : 1;
        bit ext = wr ? cfg_wr_ext : cfg_rd_ext;
        int nat = (wr ? int'(cfg_we_wid) : int'(cfg_oe_wid)) + 1;
        int lead = (wr ? int'(cfg_we_lead) : int'(cfg_oe_lead)) + 1;
        int len;
        exp_t v = '0;
        v.busy = 1;
        v.ea = cfg_shared ? 32'h0 : a;
        tmo = 0;
        for (int ai = 0; ai < na; ai++) begin          // R2 R3 R4
            v.adoe = cfg_shared;
            v.ad   = cfg_shared ? beat(a, ai) : 16'h0;
            v.par  = cfg_shared ? bpar(v.ad) : 2'b00;
            v.ale = 0; push(int'(cfg_asetup) + 1, v);
            v.ale = 1; push(int'(cfg_alewid) + 1, v);
            v.ale = 0; push(int'(cfg_ahold) + 1, v);
        end
        for (int di = 0; di < nb; di++) begin          // R6 R7 R8 R9
            v.cs = 1; v.adoe = wr;
            v.ad  = wr ? beat(w, di) : 16'h0;
            v.par = wr ? bpar(v.ad) : 2'b00;
            v.we = 0; v.oe = 0; push(lead, v);
            if (ext) begin
                if (ack_at > 0 && ack_at <= WDOG) len = ack_at;
                else begin len = WDOG; tmo = 1; end
            end else
                len = (ack_at > 0 && ack_at < nat) ? ack_at : nat;
            v.we = wr; v.oe = !wr; push(len, v);
            if (tmo) break;                            // R10
            v.we = 0; v.oe = 0;
            push(wr ? int'(cfg_we_tail) + 1 : 1, v);
        end
        v.cs = 0; v.we = 0; v.oe = 0; v.ale = 0; v.adoe = 0; v.ad = 0; v.par = 0;
        v.done = 1; v.tmo = tmo;
        v.perr = !wr && !tmo && bad_beat < nb && (bad_mask[0] || (bad_mask[1] && !cfg_narrow));
        push(1, v);
    endtask

    task automatic xfer(input bit wr, input logic [31:0] a, input logic [31:0] w,
                        input int poke);
        bit tmo;
        @(negedge clk);
        plan(wr, a, w, tmo);
        ridx = 0;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = w;
        @(negedge clk);
        req_valid = 0; req_addr = 32'hDEAD_0000; req_wdata = 32'h0BAD_F00D;
        if (poke > 0) begin                            // R13 request while busy
            repeat (poke) @(negedge clk);
            req_valid = 1; req_write = !wr; req_addr = 32'h1357_9BDF;
            @(negedge clk);
            req_valid = 0;
        end
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        if (!wr && !tmo) chk("R7 R5 rdata", rdata, rd_word);
        chk("R13 idle busy", 32'(busy), 32'h0);
    endtask

    // per-cycle comparison and device responder
    always @(posedge clk) begin
        exp_t e;
        logic strobe;
        #1;
        e = (q.size() > 0) ? q.pop_front() : exp_t'(0);
        if (!rst) begin
            chk("R6 cs",     32'(cs),      32'(e.cs));
            chk("R2 ale",    32'(ale),     32'(e.ale));
            chk("R6 we",     32'(we),      32'(e.we));
            chk("R7 oe",     32'(oe),      32'(e.oe));
            chk("R4 ad_oe",  32'(ad_oe),   32'(e.adoe));
            chk("R5 ad_out", 32'(ad_out),  32'(e.ad));
            chk("R11 par",   32'(par_out), 32'(e.par));
            chk("R3 addr",   ext_addr,     e.ea);
            chk("R13 busy",  32'(busy),    32'(e.busy));
            chk("R13 done",  32'(done),    32'(e.done));
            chk("R12 perr",  32'(par_err), 32'(e.perr));
            chk("R10 tmo",   32'(tmo_err), 32'(e.tmo));
        end
        strobe = we | oe;
        if (prev_strobe && !strobe) ridx = ridx + 1;
        sn = strobe ? sn + 1 : 0;
        ack = strobe && ack_at > 0 && sn == ack_at;
        ad_in = beat(rd_word, ridx);
        par_in = bpar(ad_in) ^ ((ridx == bad_beat) ? bad_mask : 2'b00);
        prev_strobe = strobe;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cs", 32'(cs), 0); chk("R1 busy", 32'(busy), 0);
        chk("R1 ad_oe", 32'(ad_oe), 0); chk("R1 done", 32'(done), 0);
        rst = 0;
        repeat (2) @(negedge clk);

        // R3 R6 R11: dedicated-address write, 16-bit, internal timing
        cfg_asetup = 1; cfg_alewid = 2; cfg_ahold = 0;
        cfg_we_lead = 1; cfg_we_wid = 3; cfg_we_tail = 2;
        cfg_oe_lead = 2; cfg_oe_wid = 4;
        xfer(1, 32'h1234_5678, 32'hCAFE_B00C, 0);

        // R7 R5: dedicated-address read, 16-bit
        rd_word = 32'hA5C3_1E7F;
        xfer(0, 32'h0000_4400, 0, 0);

        // R4 R5 R11: shared-bus write, 16-bit, odd parity
        cfg_shared = 1; cfg_odd = 1;
        xfer(1, 32'h8001_7FFE, 32'h0F0F_F0F0, 0);

        // R4: shared-bus write, 8-bit
        cfg_narrow = 1;
        xfer(1, 32'hDEAD_BEEF, 32'h0123_4567, 0);

        // R4 R5: shared-bus read, 8-bit, even parity
        cfg_odd = 0; rd_word = 32'h89AB_CDEF;
        xfer(0, 32'h0000_0010, 0, 0);

        // R8: early acknowledge shortens the read strobe
        cfg_narrow = 0; ack_at = 2; rd_word = 32'h3C3C_5A5A;
        xfer(0, 32'h0000_2000, 0, 0);

        // R9: external-only write waits past the pulse count
        cfg_wr_ext = 1; ack_at = 9; cfg_we_wid = 1;
        xfer(1, 32'h7777_0000, 32'h1111_2222, 0);

        // R10: external-only read with no acknowledge times out
        cfg_rd_ext = 1; ack_at = 0;
        xfer(0, 32'h0000_0040, 0, 0);
        cfg_rd_ext = 0; cfg_wr_ext = 0;

        // R12: bad lane 0 on read beat 1, 16-bit
        rd_word = 32'hFFFF_0001; bad_beat = 1; bad_mask = 2'b01;
        xfer(0, 32'h0000_0080, 0, 0);

        // R12: bad lane 1 on an 8-bit bus is ignored
        cfg_narrow = 1; bad_beat = 2; bad_mask = 2'b10;
        xfer(0, 32'h0000_0084, 0, 0);
        bad_beat = 99; bad_mask = 0;

        // R2 R13: zero counts, request while busy ignored
        cfg_shared = 0; cfg_narrow = 0;
        cfg_asetup = 0; cfg_alewid = 0; cfg_ahold = 0;
        cfg_we_lead = 0; cfg_we_wid = 0; cfg_we_tail = 0;
        xfer(1, 32'hFACE_0001, 32'h5555_AAAA, 3);
        cfg_oe_lead = 0; cfg_oe_wid = 0; rd_word = 32'h0246_8ACE;
        xfer(0, 32'hFACE_0002, 0, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule